// File: doc/BRIEF.md
# Battery Thermistor Window Qualifier

This block decides whether the battery pack temperature allows charging. It takes the thermistor node voltage as a digitized ratio of the reference, for example a 12-bit code, together with a flag that says a charge is running and a one-millisecond tick. From these it produces a temperature-ok flag and a suspend request. It also keeps three registered status bits that show whether the node is on the cold side, the hot side, or past the cut-off.

A high ratio means a cold pack and a low ratio means a hot pack. Before a charge starts, the accepted window lies between a cold limit (about 73.5 %) and a start hot limit (about 47.2 %). While a charge is running, the lower bound widens to a cut-off limit (about 44.7 %). Once the pack has been judged out of range, it is only accepted again inside the stricter start window. The cold bound is lowered by a small hysteresis for that return.

Every change of verdict is deglitched in millisecond ticks. Leaving the window must persist for 400 ticks. Returning to it must persist for 20 ticks. A timer starts again from zero whenever its condition lapses before it completes. The power management logic uses temp-ok to gate charging and suspend to stop a charge that is already under way.

Top module: `therm_window_qual`

## Requirements
- R1: After reset temp_ok_o=0, suspend_o=0, cold_o=0, hot_o=0 and cutoff_o=0, and temp_ok_o stays 0 until a return-to-window deglitch completes.
- R2: cold_o sets one clock after code_i > 3010 (0.735 of 4096). It clears one clock after code_i < 2994 (cold limit minus 16, i.e. 0.004 of 4096), and it holds for codes from 2994 to 3010.
- R3: hot_o = (code_i < 1933) and cutoff_o = (code_i < 1830), each registered one clock after the code; 1933 itself is not hot.
- R4: While not ok, temp_ok_o rises on the 20th consecutive tick during which 1933 <= code_i < 2994.
- R5: While ok and charging_i=0, code_i > 3010 or code_i < 1933 counts as out of range. While ok and charging_i=1, code_i > 3010 or code_i < 1830 counts as out of range. temp_ok_o falls on the 400th consecutive out-of-range tick.
- R6: Either deglitch count restarts from zero when its condition lapses for a clock before completion, and it advances only on cycles with tick_i=1.
- R7: suspend_o sets in the same clock that temp_ok_o falls from 1, clears when temp_ok_o returns to 1, and is never 1 together with temp_ok_o.
- R8: After a suspend, a code that is inside the charging window but outside the start window (1830 <= code < 1933) does not restore temp_ok_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | 12 | Thermistor node voltage as a fraction of the reference, full scale 4096 |
| charging_i | input | 1 | High while a charge is in progress; selects the cut-off lower bound |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| temp_ok_o | output | 1 | Deglitched verdict that the temperature permits charging |
| suspend_o | output | 1 | Charge suspend request after a deglitched excursion from ok |
| cold_o | output | 1 | Registered cold status with hysteresis |
| hot_o | output | 1 | Registered below-start-limit status |
| cutoff_o | output | 1 | Registered below-cut-off status |

## Verification
The status bits are due one clock after a code change. The bench therefore drives a new code on a falling edge and compares one full clock later. temp_ok_o and suspend_o move on the rising edge that samples the deciding tick. Each tick is driven for exactly one clock, so the expected value is queued at the falling edge right after the last tick and sampled two nanoseconds later. The counts are probed one tick short of and exactly at the 20 and 400 limits, and after a lapse that restarts the count.

// File: rtl/therm_window_pkg.sv
package therm_window_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_OK   = 1'b1
  } tw_state_e;

  // ratio in basis points (1/10000 of reference) to an ADC code of w bits
  function automatic int unsigned bp_to_code(input int unsigned bp, input int unsigned w);
    longint unsigned full;
    full = longint'(1) << w;
    return int'((longint'(bp) * full) / 10000);
  endfunction

endpackage

// File: rtl/tw_classify.sv
module tw_classify #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned COLD_C = 3010,
  parameter int unsigned HYST_C = 16,
  parameter int unsigned HOT_C  = 1933,
  parameter int unsigned CUT_C  = 1830
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              above_cold_o,
  output logic              below_rec_o,
  output logic              below_hot_o,
  output logic              below_cut_o,
  output logic              cold_st_o,
  output logic              hot_st_o,
  output logic              cut_st_o
);

  localparam logic [CODE_W-1:0] COLD_V = CODE_W'(COLD_C);
  localparam logic [CODE_W-1:0] REC_V  = CODE_W'(COLD_C - HYST_C);
  localparam logic [CODE_W-1:0] HOT_V  = CODE_W'(HOT_C);
  localparam logic [CODE_W-1:0] CUT_V  = CODE_W'(CUT_C);

  always_comb begin
    above_cold_o = code_i > COLD_V;
    below_rec_o  = code_i < REC_V;
    below_hot_o  = code_i < HOT_V;
    below_cut_o  = code_i < CUT_V;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cold_st_o <= 1'b0;
      hot_st_o  <= 1'b0;
      cut_st_o  <= 1'b0;
    end else begin
      if (above_cold_o)     cold_st_o <= 1'b1;
      else if (below_rec_o) cold_st_o <= 1'b0;
      hot_st_o <= below_hot_o;
      cut_st_o <= below_cut_o;
    end
  end

  // R3: the cut-off limit lies below the start hot limit
  p_cut_implies_hot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut_st_o |-> hot_st_o);

  // R2: in the hysteresis band the cold status holds its value
  p_cold_band_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!above_cold_o && !below_rec_o) |=> $stable(cold_st_o));

endmodule

// File: rtl/tw_deglitch.sv
module tw_deglitch #(
  parameter int unsigned LIMIT = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cond_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = cond_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!cond_i)  cnt_q <= '0;
    else if (tick_i)   cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R6: count stays below its limit
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));

  // R6: a lapse of the condition restarts the count
  p_cnt_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> cnt_q == '0);

  // R6: the count moves only on a tick
  p_cnt_tick_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && cond_i) |=> $stable(cnt_q));

endmodule

// File: rtl/therm_window_qual.sv
module therm_window_qual
  import therm_window_pkg::*;
#(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned COLD_BP  = 7350,
  parameter int unsigned HYST_BP  = 40,
  parameter int unsigned HOT_BP   = 4720,
  parameter int unsigned CUT_BP   = 4470,
  parameter int unsigned LEAVE_MS = 400,
  parameter int unsigned ENTER_MS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              charging_i,
  input  logic              tick_i,
  output logic              temp_ok_o,
  output logic              suspend_o,
  output logic              cold_o,
  output logic              hot_o,
  output logic              cutoff_o
);

  localparam int unsigned COLD_C = bp_to_code(COLD_BP, CODE_W);
  localparam int unsigned HYST_C = bp_to_code(HYST_BP, CODE_W);
  localparam int unsigned HOT_C  = bp_to_code(HOT_BP, CODE_W);
  localparam int unsigned CUT_C  = bp_to_code(CUT_BP, CODE_W);

  tw_state_e state_q;
  logic      susp_q;
  logic      above_cold, below_rec, below_hot, below_cut;
  logic      out_run, in_start, leave_done, enter_done;

  tw_classify #(
    .CODE_W(CODE_W), .COLD_C(COLD_C), .HYST_C(HYST_C),
    .HOT_C(HOT_C), .CUT_C(CUT_C)
  ) u_classify (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .code_i      (code_i),
    .above_cold_o(above_cold),
    .below_rec_o (below_rec),
    .below_hot_o (below_hot),
    .below_cut_o (below_cut),
    .cold_st_o   (cold_o),
    .hot_st_o    (hot_o),
    .cut_st_o    (cutoff_o)
  );

  // lower bound relaxes to cut-off only while charging
  always_comb begin
    out_run  = above_cold || (charging_i ? below_cut : below_hot);
    in_start = below_rec && !below_hot;
  end

  tw_deglitch #(.LIMIT(LEAVE_MS)) u_leave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cond_i((state_q == ST_OK) && out_run),
    .done_o(leave_done)
  );

  tw_deglitch #(.LIMIT(ENTER_MS)) u_enter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cond_i((state_q == ST_HOLD) && in_start),
    .done_o(enter_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      susp_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OK:   if (leave_done) begin state_q <= ST_HOLD; susp_q <= 1'b1; end
        ST_HOLD: if (enter_done) begin state_q <= ST_OK;   susp_q <= 1'b0; end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign temp_ok_o = (state_q == ST_OK);
  assign suspend_o = susp_q;

  // R7: never ok and suspended at once
  p_ok_excl_susp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(temp_ok_o && suspend_o));

  // R7: suspend rises only out of the ok state
  p_susp_from_ok_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspend_o) |-> $past(temp_ok_o));

  // R4: ok is granted only on a tick inside the start window
  p_ok_rise_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(temp_ok_o) |-> $past(tick_i) && $past(in_start));

  // R5: ok is withdrawn only on a tick while out of range
  p_ok_fall_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(temp_ok_o) |-> $past(tick_i) && $past(out_run));

endmodule

// File: tb/therm_window_qual_bench.sv
module therm_window_qual_bench;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct {
    logic  ok;
    logic  susp;
    logic  cold;
    logic  hot;
    logic  cut;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] code = 12'd2400;
  logic        charging = 1'b0;
  logic        tick = 1'b0;
  logic        ok, susp, cold, hot, cut;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  therm_window_qual u_therm_window_qual (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .code_i    (code),
    .charging_i(charging),
    .tick_i    (tick),
    .temp_ok_o (ok),
    .suspend_o (susp),
    .cold_o    (cold),
    .hot_o     (hot),
    .cutoff_o  (cut)
  );

  task automatic expect_now(input logic e_ok, input logic e_susp, input logic e_cold,
                            input logic e_hot, input logic e_cut, input string tag);
    exp_t it;
    it.ok = e_ok; it.susp = e_susp; it.cold = e_cold; it.hot = e_hot; it.cut = e_cut;
    it.tag = tag;
    exp_q.push_back(it);
    #3;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_code(input int v);
    @(negedge clk); code = 12'(v);
    @(negedge clk);
  endtask

  // monitor: pops each expected item and compares against the ports
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      #2;
      begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if ({ok, susp, cold, hot, cut} !== {it.ok, it.susp, it.cold, it.hot, it.cut}) begin
          errors++;
          $display("FAIL %s: ok/susp/cold/hot/cut actual %b%b%b%b%b expected %b%b%b%b%b",
                   it.tag, ok, susp, cold, hot, cut, it.ok, it.susp, it.cold, it.hot, it.cut);
        end
      end
    end
  end

  initial begin
    #4ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now(0, 0, 0, 0, 0, "R1 reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now(0, 0, 0, 0, 0, "R1 not ok without ticks");

    // R4: first acceptance after 20 ticks in start window
    tick_n(19);
    expect_now(0, 0, 0, 0, 0, "R4 19 ticks not yet ok");
    tick_n(1);
    expect_now(1, 0, 0, 0, 0, "R4 ok on 20th tick");

    // R5/R6: hot excursion while idle, interrupted then completed
    set_code(1900);
    expect_now(1, 0, 0, 1, 0, "R3 hot status");
    tick_n(200);
    set_code(2400);
    set_code(1900);
    tick_n(399);
    expect_now(1, 0, 0, 1, 0, "R6 restart after lapse");
    tick_n(1);
    expect_now(0, 1, 0, 1, 0, "R5 R7 idle hot suspend");

    // R6: no ticks means no progress
    set_code(1950);
    repeat (100) @(negedge clk);
    expect_now(0, 1, 0, 0, 0, "R6 no ticks no change");
    tick_n(19);
    expect_now(0, 1, 0, 0, 0, "R4 19 ticks still held");
    tick_n(1);
    expect_now(1, 0, 0, 0, 0, "R4 R7 resume clears suspend");

    // R5: charging relaxes lower bound to cut-off
    @(negedge clk); charging = 1'b1;
    set_code(1850);
    tick_n(450);
    expect_now(1, 0, 0, 1, 0, "R5 charging window holds");
    set_code(1800);
    expect_now(1, 0, 0, 1, 1, "R3 cutoff status");
    tick_n(399);
    expect_now(1, 0, 0, 1, 1, "R5 cutoff 399 ticks");
    tick_n(1);
    expect_now(0, 1, 0, 1, 1, "R5 cutoff suspend");

    // R8: charging window is not enough to resume
    set_code(1850);
    tick_n(30);
    expect_now(0, 1, 0, 1, 0, "R8 no resume below start limit");

    // R2: cold hysteresis
    set_code(3020);
    expect_now(0, 1, 1, 0, 0, "R2 cold set");
    set_code(3000);
    expect_now(0, 1, 1, 0, 0, "R2 cold held in band");
    set_code(2994);
    tick_n(25);
    expect_now(0, 1, 1, 0, 0, "R2 R4 2994 no recovery");
    set_code(2993);
    expect_now(0, 1, 0, 0, 0, "R2 cold clears below band");
    tick_n(20);
    expect_now(1, 0, 0, 0, 0, "R4 cold recovery");

    // R2/R5: cold boundary and cold suspend while charging
    set_code(3010);
    tick_n(5);
    expect_now(1, 0, 0, 0, 0, "R2 3010 not cold");
    set_code(3011);
    tick_n(399);
    expect_now(1, 0, 1, 0, 0, "R5 cold 399 ticks");
    tick_n(1);
    expect_now(0, 1, 1, 0, 0, "R5 cold suspend");

    // R3/R6: hot boundary and restart of the return count
    set_code(1933);
    expect_now(0, 1, 0, 0, 0, "R3 1933 not hot");
    tick_n(10);
    set_code(3020);
    set_code(1933);
    tick_n(19);
    expect_now(0, 1, 0, 0, 0, "R6 return count restarted");
    tick_n(1);
    expect_now(1, 0, 0, 0, 0, "R4 R7 ok after restart");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule